// File: doc/BRIEF.md
# Idle-Gated Memory Path Selector

This block sits between one upstream memory-access port and two downstream memory controllers: an octal SPI flash controller and a HyperBus controller. At any moment exactly one of them is the active target. Requests go only to that target, and responses come back only from it. The upstream port carries 32-bit addresses and 64-bit data, and it may have several requests issued before their responses return.

Software picks the target by writing a select bit through a small configuration write port. The write does not redirect traffic at once. It records a requested path, and the block applies it on the first cycle that the port is idle. Idle means no transaction is outstanding and no request is being presented. The block never stalls, drains or aborts traffic to make a switch happen; stopping traffic is left to software. Two status outputs report the active path and whether a requested change is still waiting.

Top module: `mem_path_sel`

## Requirements
- R1: After reset the active path is the octal SPI controller (`sel_active` = 0), `sel_pending` is 0 and no transaction is counted as outstanding.
- R2: A cycle with `cfg_wr_en` high records `cfg_wr_sel` (0 = octal SPI, 1 = HyperBus) as the requested path from the next cycle on. `sel_pending` is high exactly while the requested path differs from the active path.
- R3: The active path takes the requested value at the clock edge that ends the first idle cycle. An idle cycle has zero outstanding transactions and `up_req_valid` low. `sel_active` shows the new path from the following cycle.
- R4: While a request is presented, the active path does not change, and the request is still forwarded to the active target. A pending switch neither blocks nor withdraws it.
- R5: The outstanding count rises by one for each accepted request (valid and ready both high). It falls by one for each accepted response beat with `*_rsp_last` high. A response beat with last low leaves the count unchanged.
- R6: Only the active target sees `*_req_valid` high. The inactive target's `*_req_valid` is held low.
- R7: `up_rsp_valid`, `up_rsp_data` and `up_rsp_last` come only from the active target, so the inactive target's response valid is ignored. The inactive target's `*_rsp_ready` is held low, and the active target's `*_rsp_ready` follows `up_rsp_ready`.
- R8: `up_req_ready` follows the active target's request ready while fewer than MAX_OUTSTANDING transactions are outstanding. At MAX_OUTSTANDING, `up_req_ready` is low and no request is forwarded.
- R9: Address, write flag and write data pass unchanged to the active target. Response data and last pass unchanged from it.
- R10: If a later write sets the requested path back to the active path before an idle cycle occurs, `sel_pending` drops and no switch takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Select register write strobe |
| cfg_wr_sel | input | 1 | Requested path: 0 octal SPI, 1 HyperBus |
| sel_active | output | 1 | Currently active path |
| sel_pending | output | 1 | Requested path differs from active path |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_addr | input | ADDR_W | Upstream request address |
| up_req_write | input | 1 | Upstream request is a write |
| up_req_wdata | input | DATA_W | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_data | output | DATA_W | Upstream response data |
| up_rsp_last | output | 1 | Final beat of a response |
| ospi_req_valid | output | 1 | Octal SPI request valid |
| ospi_req_ready | input | 1 | Octal SPI request ready |
| ospi_req_addr | output | ADDR_W | Octal SPI request address |
| ospi_req_write | output | 1 | Octal SPI request write flag |
| ospi_req_wdata | output | DATA_W | Octal SPI write data |
| ospi_rsp_valid | input | 1 | Octal SPI response valid |
| ospi_rsp_ready | output | 1 | Octal SPI response ready |
| ospi_rsp_data | input | DATA_W | Octal SPI response data |
| ospi_rsp_last | input | 1 | Octal SPI final response beat |
| hbus_req_valid | output | 1 | HyperBus request valid |
| hbus_req_ready | input | 1 | HyperBus request ready |
| hbus_req_addr | output | ADDR_W | HyperBus request address |
| hbus_req_write | output | 1 | HyperBus request write flag |
| hbus_req_wdata | output | DATA_W | HyperBus write data |
| hbus_rsp_valid | input | 1 | HyperBus response valid |
| hbus_rsp_ready | output | 1 | HyperBus response ready |
| hbus_rsp_data | input | DATA_W | HyperBus response data |
| hbus_rsp_last | input | 1 | HyperBus final response beat |

## Verification
The assertions rely on two input conditions. First, the active target returns a final response beat only when it owes one, so the outstanding count never goes below zero. Second, `up_req_valid` does not depend on `up_req_ready` in the same cycle. The stimulus honours both. It raises a response valid on the active target only when the bench model's count is above zero, and it chooses every input right after the clock edge, before it looks at any output. The inactive target gets unconstrained response valids, because the block must ignore them. Random phases alternate between busy stretches and quiet stretches, so switches are requested both while traffic is in flight and while the port is idle.

// File: rtl/mps_pkg.sv
// Package: shared types for the memory path selector.
// Assumes exactly two downstream targets, indexed by the path encoding.
package mps_pkg;
    typedef enum logic {
        PATH_OSPI = 1'b0,
        PATH_HBUS = 1'b1
    } path_e;

    localparam int NUM_PATHS = 2;
endpackage

// File: rtl/mps_txn_counter.sv
// Module: outstanding-transaction counter.
// Counts accepted requests minus completed responses. Reports empty and full.
// Assumes a decrement never arrives at zero; if one does, it is ignored.
module mps_txn_counter #(
    parameter int MAX_OUT = 16,
    parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;
    logic             dec_ok;

    // Guard against underflow on an unexpected completion.
    assign dec_ok = dec && (cnt_q != '0);

    // Update the count; a simultaneous increment and decrement cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt   = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q >= LIMIT);
endmodule

// File: rtl/mps_sel_ctrl.sv
// Module: select control.
// Holds the software-requested path and the active path. The requested
// path is copied to the active path at the end of a cycle that is idle.
// Assumes idle is already qualified by the caller.
module mps_sel_ctrl
    import mps_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_sel,
    input  logic  idle,
    output path_e active,
    output logic  mismatch
);
    path_e req_q;
    path_e act_q;

    // Record the requested path on every register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= PATH_OSPI;
        end else if (wr_en) begin
            req_q <= path_e'(wr_sel);
        end
    end

    // Apply the requested path only during an idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= PATH_OSPI;
        end else if (idle) begin
            act_q <= req_q;
        end
    end

    assign active   = act_q;
    assign mismatch = (req_q != act_q);
endmodule

// File: rtl/mps_route.sv
// Module: channel router.
// Steers request valid to the active target and response ready back to it.
// Selects the ready, response valid and response payload from the active
// target. Request payload is broadcast; only the valid line qualifies it.
// Assumes `block` is high when no further request may be accepted.
module mps_route
    import mps_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  path_e                 active,
    input  logic                  block,
    input  logic                  up_req_valid,
    output logic                  up_req_ready,
    output logic                  up_rsp_valid,
    input  logic                  up_rsp_ready,
    output logic [DATA_W-1:0]     up_rsp_data,
    output logic                  up_rsp_last,
    output logic [NUM_PATHS-1:0]  t_req_valid,
    input  logic [NUM_PATHS-1:0]  t_req_ready,
    input  logic [NUM_PATHS-1:0]  t_rsp_valid,
    output logic [NUM_PATHS-1:0]  t_rsp_ready,
    input  logic [DATA_W-1:0]     t_rsp_data [NUM_PATHS],
    input  logic [NUM_PATHS-1:0]  t_rsp_last
);
    logic [NUM_PATHS-1:0] hit;

    // Per-target gating of the valid and ready lines toward each target.
    for (genvar t = 0; t < NUM_PATHS; t++) begin : g_tgt
        assign hit[t]         = (active == path_e'(t));
        assign t_req_valid[t] = hit[t] && up_req_valid && !block;
        assign t_rsp_ready[t] = hit[t] && up_rsp_ready;
    end

    // Select the upstream-facing signals from the active target.
    always_comb begin
        up_req_ready = !block && t_req_ready[active];
        up_rsp_valid = t_rsp_valid[active];
        up_rsp_data  = t_rsp_data[active];
        up_rsp_last  = t_rsp_last[active];
    end
endmodule

// File: rtl/mem_path_sel.sv
// Module: idle-gated memory path selector (top).
// Routes one upstream port to the octal SPI or the HyperBus controller.
// A software-written select takes effect only when the port is idle.
// Assumes targets return a final beat only for accepted requests.
module mem_path_sel
    import mps_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int DATA_W          = 64,
    parameter int MAX_OUTSTANDING = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    output logic              sel_active,
    output logic              sel_pending,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_write,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic [DATA_W-1:0] up_rsp_data,
    output logic              up_rsp_last,
    output logic              ospi_req_valid,
    input  logic              ospi_req_ready,
    output logic [ADDR_W-1:0] ospi_req_addr,
    output logic              ospi_req_write,
    output logic [DATA_W-1:0] ospi_req_wdata,
    input  logic              ospi_rsp_valid,
    output logic              ospi_rsp_ready,
    input  logic [DATA_W-1:0] ospi_rsp_data,
    input  logic              ospi_rsp_last,
    output logic              hbus_req_valid,
    input  logic              hbus_req_ready,
    output logic [ADDR_W-1:0] hbus_req_addr,
    output logic              hbus_req_write,
    output logic [DATA_W-1:0] hbus_req_wdata,
    input  logic              hbus_rsp_valid,
    output logic              hbus_rsp_ready,
    input  logic [DATA_W-1:0] hbus_rsp_data,
    input  logic              hbus_rsp_last
);
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1);

    path_e                active;
    logic [CNT_W-1:0]     txn_cnt;
    logic                 cnt_empty;
    logic                 cnt_full;
    logic                 port_idle;
    logic                 req_fire;
    logic                 rsp_done;
    logic [NUM_PATHS-1:0] t_req_valid;
    logic [NUM_PATHS-1:0] t_req_ready;
    logic [NUM_PATHS-1:0] t_rsp_valid;
    logic [NUM_PATHS-1:0] t_rsp_ready;
    logic [NUM_PATHS-1:0] t_rsp_last;
    logic [DATA_W-1:0]    t_rsp_data [NUM_PATHS];

    // Gather the target channels into arrays indexed by path encoding.
    assign t_req_ready = {hbus_req_ready, ospi_req_ready};
    assign t_rsp_valid = {hbus_rsp_valid, ospi_rsp_valid};
    assign t_rsp_last  = {hbus_rsp_last,  ospi_rsp_last};
    assign t_rsp_data[PATH_OSPI] = ospi_rsp_data;
    assign t_rsp_data[PATH_HBUS] = hbus_rsp_data;

    assign ospi_req_valid = t_req_valid[PATH_OSPI];
    assign hbus_req_valid = t_req_valid[PATH_HBUS];
    assign ospi_rsp_ready = t_rsp_ready[PATH_OSPI];
    assign hbus_rsp_ready = t_rsp_ready[PATH_HBUS];

    // Request payload is shared; the valid line selects the consumer.
    assign ospi_req_addr  = up_req_addr;
    assign ospi_req_write = up_req_write;
    assign ospi_req_wdata = up_req_wdata;
    assign hbus_req_addr  = up_req_addr;
    assign hbus_req_write = up_req_write;
    assign hbus_req_wdata = up_req_wdata;

    // Handshake events that move the outstanding count.
    assign req_fire  = up_req_valid && up_req_ready;
    assign rsp_done  = up_rsp_valid && up_rsp_ready && up_rsp_last;
    assign port_idle = cnt_empty && !up_req_valid;

    mps_txn_counter #(
        .MAX_OUT (MAX_OUTSTANDING),
        .CNT_W   (CNT_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (req_fire),
        .dec   (rsp_done),
        .cnt   (txn_cnt),
        .empty (cnt_empty),
        .full  (cnt_full)
    );

    mps_sel_ctrl sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .idle     (port_idle),
        .active   (active),
        .mismatch (sel_pending)
    );

    mps_route #(
        .DATA_W (DATA_W)
    ) route_i (
        .active       (active),
        .block        (cnt_full),
        .up_req_valid (up_req_valid),
        .up_req_ready (up_req_ready),
        .up_rsp_valid (up_rsp_valid),
        .up_rsp_ready (up_rsp_ready),
        .up_rsp_data  (up_rsp_data),
        .up_rsp_last  (up_rsp_last),
        .t_req_valid  (t_req_valid),
        .t_req_ready  (t_req_ready),
        .t_rsp_valid  (t_rsp_valid),
        .t_rsp_ready  (t_rsp_ready),
        .t_rsp_data   (t_rsp_data),
        .t_rsp_last   (t_rsp_last)
    );

    assign sel_active = active;
endmodule

// File: rtl/mps_checker.sv
// Module: assertion checker for mem_path_sel, attached by bind.
// Assumes final response beats arrive only while transactions are owed.
module mps_checker #(
    parameter int MAX_OUT = 16,
    parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             sel_active,
    input logic             sel_pending,
    input logic             up_req_valid,
    input logic             up_req_ready,
    input logic             up_rsp_valid,
    input logic             ospi_req_valid,
    input logic             hbus_req_valid,
    input logic             ospi_rsp_valid,
    input logic             hbus_rsp_valid,
    input logic             ospi_rsp_ready,
    input logic             hbus_rsp_ready,
    input logic [CNT_W-1:0] cnt
);
    logic past_ok;

    // Mark when the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    AST_OSPI_REQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |-> !hbus_req_valid);                                  // R6
    AST_HBUS_REQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active |-> !ospi_req_valid);                                   // R6
    AST_INACTIVE_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active ? !ospi_rsp_ready : !hbus_rsp_ready);                   // R7
    AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |-> (sel_active ? hbus_rsp_valid : ospi_rsp_valid));  // R7
    AST_SWITCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (sel_active != $past(sel_active)) |-> ($past(cnt) == '0 && !$past(up_req_valid))); // R3
    AST_BUSY_HOLDS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 || up_req_valid) |=> $stable(sel_active));              // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_OUT));                                           // R8
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(MAX_OUT)) |-> !up_req_ready);                       // R8
    AST_NO_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_pending && !cfg_wr_en) |=> $stable(sel_active));             // R2
endmodule

bind mem_path_sel mps_checker #(
    .MAX_OUT (MAX_OUTSTANDING),
    .CNT_W   (CNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_en      (cfg_wr_en),
    .sel_active     (sel_active),
    .sel_pending    (sel_pending),
    .up_req_valid   (up_req_valid),
    .up_req_ready   (up_req_ready),
    .up_rsp_valid   (up_rsp_valid),
    .ospi_req_valid (ospi_req_valid),
    .hbus_req_valid (hbus_req_valid),
    .ospi_rsp_valid (ospi_rsp_valid),
    .hbus_rsp_valid (hbus_rsp_valid),
    .ospi_rsp_ready (ospi_rsp_ready),
    .hbus_rsp_ready (hbus_rsp_ready),
    .cnt            (txn_cnt)
);

// File: tb/mem_path_sel_tb_top.sv
// Bench: reference model checked every cycle, plus directed scenarios.
module mem_path_sel_tb_top;
    localparam int AW  = 32;
    localparam int DW  = 64;
    localparam int MAX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
    logic          sel_active, sel_pending;
    logic          up_req_valid = 1'b0, up_req_ready;
    logic [AW-1:0] up_req_addr = '0;
    logic          up_req_write = 1'b0;
    logic [DW-1:0] up_req_wdata = '0;
    logic          up_rsp_valid, up_rsp_ready = 1'b0;
    logic [DW-1:0] up_rsp_data;
    logic          up_rsp_last;
    logic          ospi_req_valid, ospi_req_ready = 1'b0;
    logic [AW-1:0] ospi_req_addr;
    logic          ospi_req_write;
    logic [DW-1:0] ospi_req_wdata;
    logic          ospi_rsp_valid = 1'b0, ospi_rsp_ready;
    logic [DW-1:0] ospi_rsp_data = '0;
    logic          ospi_rsp_last = 1'b0;
    logic          hbus_req_valid, hbus_req_ready = 1'b0;
    logic [AW-1:0] hbus_req_addr;
    logic          hbus_req_write;
    logic [DW-1:0] hbus_req_wdata;
    logic          hbus_rsp_valid = 1'b0, hbus_rsp_ready;
    logic [DW-1:0] hbus_rsp_data = '0;
    logic          hbus_rsp_last = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;
    bit model_on = 0;

    int m_act  = 0;
    int m_pend = 0;
    int m_cnt  = 0;

    always #2.5 clk = ~clk;

    mem_path_sel #(.ADDR_W(AW), .DATA_W(DW), .MAX_OUTSTANDING(MAX)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model: compare outputs, then advance state for the next edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_cnt = 0;
            model_on = 1;
        end else if (model_on) begin
            bit full, e_rdy, e_rv, e_last, acc, done, idle;
            logic [DW-1:0] e_data;
            full   = (m_cnt >= MAX);
            e_rdy  = !full && (m_act == 1 ? hbus_req_ready : ospi_req_ready);
            e_rv   = (m_act == 1) ? hbus_rsp_valid : ospi_rsp_valid;
            e_last = (m_act == 1) ? hbus_rsp_last : ospi_rsp_last;
            e_data = (m_act == 1) ? hbus_rsp_data : ospi_rsp_data;
            chk(sel_active == m_act[0], "R3 sel_active", 64'(sel_active), 64'(m_act));
            chk(sel_pending == (m_pend != m_act), "R2 sel_pending", 64'(sel_pending), 64'(m_pend != m_act));
            chk(up_req_ready == e_rdy, "R8 up_req_ready", 64'(up_req_ready), 64'(e_rdy));
            chk(ospi_req_valid == (up_req_valid && !full && m_act == 0), "R6 ospi_req_valid",
                64'(ospi_req_valid), 64'(up_req_valid && !full && m_act == 0));
            chk(hbus_req_valid == (up_req_valid && !full && m_act == 1), "R6 hbus_req_valid",
                64'(hbus_req_valid), 64'(up_req_valid && !full && m_act == 1));
            chk(ospi_rsp_ready == (up_rsp_ready && m_act == 0), "R7 ospi_rsp_ready",
                64'(ospi_rsp_ready), 64'(up_rsp_ready && m_act == 0));
            chk(hbus_rsp_ready == (up_rsp_ready && m_act == 1), "R7 hbus_rsp_ready",
                64'(hbus_rsp_ready), 64'(up_rsp_ready && m_act == 1));
            chk(up_rsp_valid == e_rv, "R7 up_rsp_valid", 64'(up_rsp_valid), 64'(e_rv));
            if (e_rv) begin
                chk(up_rsp_data == e_data, "R9 up_rsp_data", up_rsp_data, e_data);
                chk(up_rsp_last == e_last, "R9 up_rsp_last", 64'(up_rsp_last), 64'(e_last));
            end
            if (up_req_valid) begin
                chk((m_act == 1 ? hbus_req_addr : ospi_req_addr) == up_req_addr, "R9 req_addr",
                    64'(m_act == 1 ? hbus_req_addr : ospi_req_addr), 64'(up_req_addr));
                chk((m_act == 1 ? hbus_req_wdata : ospi_req_wdata) == up_req_wdata, "R9 req_wdata",
                    (m_act == 1 ? hbus_req_wdata : ospi_req_wdata), up_req_wdata);
                chk((m_act == 1 ? hbus_req_write : ospi_req_write) == up_req_write, "R9 req_write",
                    64'(m_act == 1 ? hbus_req_write : ospi_req_write), 64'(up_req_write));
            end
            acc  = up_req_valid && e_rdy;
            done = e_rv && up_rsp_ready && e_last && (m_cnt > 0);
            idle = (m_cnt == 0) && !up_req_valid;
            if (idle) m_act = m_pend;
            if (cfg_wr_en) m_pend = int'(cfg_wr_sel);
            m_cnt = m_cnt + int'(acc) - int'(done);
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic quiet();
        cfg_wr_en = 0; up_req_valid = 0; up_rsp_ready = 0;
        ospi_req_ready = 0; hbus_req_ready = 0;
        ospi_rsp_valid = 0; hbus_rsp_valid = 0;
        ospi_rsp_last = 0; hbus_rsp_last = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cfg_write(input logic v);
        cfg_wr_en = 1; cfg_wr_sel = v; step(); cfg_wr_en = 0;
    endtask

    initial begin
        quiet();
        repeat (3) step();
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(sel_active == 0, "R1 sel_active", 64'(sel_active), 0);
        chk(sel_pending == 0, "R1 sel_pending", 64'(sel_pending), 0);
        chk(hbus_req_valid == 0, "R1 hbus_req_valid", 64'(hbus_req_valid), 0);
        step();

        // R2/R3: switch to HyperBus on an idle port
        cfg_write(1);
        @(negedge clk);
        chk(sel_pending == 1 && sel_active == 0, "R2 pending after write", {sel_pending, sel_active}, 64'b10);
        @(negedge clk);
        chk(sel_active == 1 && sel_pending == 0, "R3 idle switch", {sel_pending, sel_active}, 64'b01);
        step();

        // R5: only the final beat retires a transaction
        hbus_req_ready = 1; up_req_valid = 1; up_req_addr = 32'h100;
        repeat (3) step();
        up_req_valid = 0;
        cfg_write(0);
        @(negedge clk);
        chk(sel_pending == 1 && sel_active == 1, "R2 pending while busy", {sel_pending, sel_active}, 64'b11);
        step();
        up_rsp_ready = 1; hbus_rsp_valid = 1; hbus_rsp_last = 0; hbus_rsp_data = 64'hA5A5_0000_1111_2222;
        step();
        hbus_rsp_last = 1;
        repeat (2) step();
        @(negedge clk);
        chk(sel_active == 1, "R5 one still outstanding", 64'(sel_active), 1);
        step();
        hbus_rsp_valid = 0;
        @(negedge clk);
        chk(sel_active == 1, "R5 switch not before idle cycle", 64'(sel_active), 1);
        @(negedge clk);
        chk(sel_active == 0, "R3 switch after drain", 64'(sel_active), 0);
        step();
        quiet();

        // R4: a presented but stalled request holds the path and is not withdrawn
        up_req_valid = 1; ospi_req_ready = 0;
        cfg_write(1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(sel_active == 0 && ospi_req_valid == 1, "R4 hold while presented",
                {ospi_req_valid, sel_active}, 64'b10);
        end
        step();
        up_req_valid = 0;
        @(negedge clk);
        chk(sel_active == 0, "R4 still held in first idle cycle", 64'(sel_active), 0);
        @(negedge clk);
        chk(sel_active == 1, "R3 switch after request withdrawn", 64'(sel_active), 1);
        step();

        // R8/R9: fill to the limit, then drain with patterned data
        hbus_req_ready = 1; up_req_valid = 1; up_req_write = 1;
        up_req_addr = 32'hDEAD_BEE0; up_req_wdata = 64'h0123_4567_89AB_CDEF;
        repeat (MAX) step();
        @(negedge clk);
        chk(up_req_ready == 0 && hbus_req_valid == 0, "R8 blocked at limit",
            {up_req_ready, hbus_req_valid}, 0);
        chk(hbus_req_addr == 32'hDEAD_BEE0, "R9 addr passthrough", 64'(hbus_req_addr), 64'hDEAD_BEE0);
        step();
        up_req_valid = 0; up_req_write = 0;
        up_rsp_ready = 1; hbus_rsp_valid = 1; hbus_rsp_last = 1; hbus_rsp_data = 64'hFEED_FACE_CAFE_0001;
        @(negedge clk);
        chk(up_rsp_data == 64'hFEED_FACE_CAFE_0001, "R9 rsp data", up_rsp_data, 64'hFEED_FACE_CAFE_0001);
        repeat (MAX) step();
        hbus_rsp_valid = 0;
        step();

        // R10: a cancelling write removes the pending switch
        up_req_valid = 1; step(); up_req_valid = 0;
        cfg_write(0);
        cfg_write(1);
        @(negedge clk);
        chk(sel_pending == 0, "R10 pending cleared", 64'(sel_pending), 0);
        step();
        hbus_rsp_valid = 1; hbus_rsp_last = 1; up_rsp_ready = 1;
        step();
        hbus_rsp_valid = 0;
        repeat (3) step();
        @(negedge clk);
        chk(sel_active == 1, "R10 no switch", 64'(sel_active), 1);

        // R7: the inactive target's response valid is ignored
        ospi_rsp_valid = 1; up_rsp_ready = 1;
        @(negedge clk);
        chk(up_rsp_valid == 0 && ospi_rsp_ready == 0 && hbus_rsp_ready == 1, "R7 inactive ignored",
            {up_rsp_valid, ospi_rsp_ready, hbus_rsp_ready}, 64'b001);
        step();
        quiet();
        step();

        // Random phases, checked every cycle by the model
        for (int c = 0; c < 3000; c++) begin
            bit busy;
            busy = ((c / 40) % 2) == 0;
            up_req_valid   = busy && ($urandom % 4 != 0);
            up_req_addr    = $urandom;
            up_req_write   = $urandom % 2;
            up_req_wdata   = {$urandom, $urandom};
            ospi_req_ready = $urandom % 2;
            hbus_req_ready = $urandom % 2;
            up_rsp_ready   = ($urandom % 4) != 0;
            ospi_rsp_data  = {$urandom, $urandom};
            hbus_rsp_data  = {$urandom, $urandom};
            ospi_rsp_last  = $urandom % 2;
            hbus_rsp_last  = $urandom % 2;
            ospi_rsp_valid = (m_act == 0) ? (m_cnt > 0 && $urandom % 2 == 1) : ($urandom % 2 == 1);
            hbus_rsp_valid = (m_act == 1) ? (m_cnt > 0 && $urandom % 2 == 1) : ($urandom % 2 == 1);
            cfg_wr_en      = ($urandom % 16) == 0;
            cfg_wr_sel     = $urandom % 2;
            step();
        end
        quiet();
        repeat (2) step();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule